// File: doc/BRIEF.md
# Flash Cache Control and Statistics Register Slave

This block is the register slave that sits beside a flash execute-in-place cache. It holds the policy bits that steer the cache: enable, power-down and the bad-write error policy. It runs the handshake that asks the cache to flush its tag state. It also reports the flush progress and the fill state of the streaming FIFO, and keeps two saturating statistics counters, one for cache hits and one for accesses. The tag and data memories, the flash interface and the FIFO itself live elsewhere. They reach this block only through single-bit side-band pins.

Software reaches the registers over a simple request/wait bus. A requester raises `bus_req` with an address, a direction and write data, and holds all of them stable while `bus_wait` is high. This is the back-pressure rule: the access completes in the first cycle in which `bus_req` is high and `bus_wait` is low. In that cycle, read data and `bus_err` are valid combinationally. Writes take effect from the following cycle. Only a read of the flush register ever waits: it stalls until the flush in progress has finished. Reset starts a flush on its own, so a freshly reset cache never serves stale tags.

Top module: `fcache_regs`

## Requirements
- R1: The control register sits at word offset 0. Enable is at bit 0 (reset 1), the bad-write error policy at bit 1 (reset 1) and power-down at bit 3 (reset 0). Bit 2 and bits 31:4 read 0. The three stored bits drive `cache_en`, `bad_write_err` and `power_down`.
- R2: A control write with bit 3 set leaves enable at 0, whatever is written to bit 0, so `cache_en` is never 1 while `power_down` is 1.
- R3: Writing 1 to bit 0 of the flush register (offset 1) raises `flush_req`. It stays high until the cycle after `flush_done` is seen. The flush register reads 0, and writing 0 to it starts nothing.
- R4: A read of the flush register while a flush runs holds `bus_wait` high. If `flush_done` arrives K cycles into the read, the read sees exactly K wait cycles and then completes with data 0.
- R5: Out of reset, a flush is already running: `flush_req` is 1 and status bit 0 is 0 until `flush_done`.
- R6: The status register (offset 2) shows flush-ready (no flush running) at bit 0, `fifo_empty` at bit 1 and `fifo_full` at bit 2. The other bits read 0, and writes to it change nothing.
- R7: The hit counter (offset 3) and the access counter (offset 4) each add one for every cycle in which their pulse input is high. Each saturates at all ones (CNT_W bits, default 32), and each reads zero-extended to 32 bits.
- R8: Any write to a counter clears it to 0. When a write and a pulse hit the same counter in the same cycle, the counter reads 0 afterwards.
- R9: `hit_pulse` moves only the hit counter, and `access_pulse` moves only the access counter.
- R10: An access to offsets 5 to 7 completes with `bus_err` high and read data 0, and it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held while bus_wait is high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the completing cycle |
| bus_wait | output | 1 | Holds the access (flush register read during a flush) |
| bus_err | output | 1 | Error response for an unmapped offset |
| hit_pulse | input | 1 | One cycle per access served from cached data |
| access_pulse | input | 1 | One cycle per access, cacheable or not |
| flush_done | input | 1 | Cache reports that the tag flush has finished |
| fifo_full | input | 1 | Streaming FIFO full flag |
| fifo_empty | input | 1 | Streaming FIFO empty flag |
| cache_en | output | 1 | Cache enable |
| power_down | output | 1 | Cache memory power-down |
| bad_write_err | output | 1 | Fault on writes to non-caching aliases |
| flush_req | output | 1 | Flush request, high until flush_done |

## Verification
Read data, `bus_wait` and `bus_err` are combinational in the completing cycle. The bench samples them one time step after the falling edge on which the request was driven, and before the rising edge that completes the access. Register writes, pulse counts and the flush handshake settle at the rising edge. Those outputs are checked one time step after that edge, or by a read issued on the following falling edge. The wait-state check counts falling edges during which `bus_wait` is seen high, and compares the count with the number of cycles after which the flush stub raises `flush_done`.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 5;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_FLUSH = 1;
  localparam int OFF_STAT  = 2;
  localparam int OFF_HITS  = 3;
  localparam int OFF_ACCS  = 4;
  localparam int NUM_CTRS  = 2;
  localparam int CTR_HITS  = 0;
  localparam int CTR_ACCS  = 1;
endpackage

// File: rtl/fcr_ctrl.sv
module fcr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wdata,
  output logic       en,
  output logic       bad_wr,
  output logic       pd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b1;
      bad_wr <= 1'b1;
      pd     <= 1'b0;
    end else if (wr_en) begin
      en     <= wdata[0] & ~wdata[3];
      bad_wr <= wdata[1];
      pd     <= wdata[3];
    end
  end

  // R2: enable never coexists with power-down
  p_pd_blocks_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !en);
endmodule

// File: rtl/fcr_flush.sv
module fcr_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b1;
    else        busy <= (busy & ~done) | start;
  end

  // R3: request held until completion is reported
  p_busy_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R3: completion without a new start ends the request
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !start) |=> !busy);
endmodule

// File: rtl/fcr_sat_ctr.sv
module fcr_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (inc && cnt != TOP)    cnt <= cnt + 1'b1;
  end

  // R7: a saturated counter stays saturated until cleared
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !clr) |=> cnt == TOP);
  // R8: a clear always wins
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/fcache_regs.sv
module fcache_regs #(
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_req,
  input  logic                      bus_we,
  input  logic [fcr_pkg::ADDR_W-1:0] bus_addr,
  input  logic [fcr_pkg::DATA_W-1:0] bus_wdata,
  output logic [fcr_pkg::DATA_W-1:0] bus_rdata,
  output logic                      bus_wait,
  output logic                      bus_err,
  input  logic                      hit_pulse,
  input  logic                      access_pulse,
  input  logic                      flush_done,
  input  logic                      fifo_full,
  input  logic                      fifo_empty,
  output logic                      cache_en,
  output logic                      power_down,
  output logic                      bad_write_err,
  output logic                      flush_req
);
  import fcr_pkg::*;

  logic             mapped, fire, wr_fire;
  logic             flush_busy;
  logic [NUM_CTRS-1:0] ctr_inc, ctr_clr;
  logic [CNT_W-1:0] ctr_val [NUM_CTRS];
  logic             unused_wdata;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign mapped   = int'(bus_addr) < NUM_REGS;
  assign bus_wait = bus_req & ~bus_we & at(bus_addr, OFF_FLUSH) & flush_busy;
  assign bus_err  = bus_req & ~mapped;
  assign fire     = bus_req & ~bus_wait;
  assign wr_fire  = fire & bus_we & mapped;
  assign unused_wdata = ^bus_wdata[DATA_W-1:4] ^ bus_wdata[2];

  fcr_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_fire & at(bus_addr, OFF_CTRL)),
    .wdata (bus_wdata[3:0]),
    .en    (cache_en),
    .bad_wr(bad_write_err),
    .pd    (power_down)
  );

  fcr_flush u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_fire & at(bus_addr, OFF_FLUSH) & bus_wdata[0]),
    .done  (flush_done),
    .busy  (flush_busy)
  );
  assign flush_req = flush_busy;

  assign ctr_inc[CTR_HITS] = hit_pulse;
  assign ctr_inc[CTR_ACCS] = access_pulse;
  assign ctr_clr[CTR_HITS] = wr_fire & at(bus_addr, OFF_HITS);
  assign ctr_clr[CTR_ACCS] = wr_fire & at(bus_addr, OFF_ACCS);

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    fcr_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc[g]),
      .clr   (ctr_clr[g]),
      .cnt   (ctr_val[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      case (int'(bus_addr))
        OFF_CTRL: bus_rdata = DATA_W'({power_down, 1'b0, bad_write_err, cache_en});
        OFF_STAT: bus_rdata = DATA_W'({fifo_full, fifo_empty, ~flush_busy});
        OFF_HITS: bus_rdata = DATA_W'(ctr_val[CTR_HITS]);
        OFF_ACCS: bus_rdata = DATA_W'(ctr_val[CTR_ACCS]);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4: the bus only stalls while a flush is outstanding
  p_wait_needs_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> flush_req);
  // R10: an error response never stalls and never writes
  p_err_no_side_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && bus_we) |=> $stable({cache_en, power_down, bad_write_err}));
endmodule

// File: tb/fcache_regs_tb.sv
module fcache_regs_tb_top;
  localparam int CW  = 4;
  localparam int MAX = (1 << CW) - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_wait, bus_err;
  logic        hit_pulse = 0, access_pulse = 0, flush_done = 0;
  logic        fifo_full = 0, fifo_empty = 1;
  logic        cache_en, power_down, bad_write_err, flush_req;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fcache_regs #(.CNT_W(CW)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic err);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
    #1 err = bus_err;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic err, output int waits);
    waits = 0;
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 3'(a);
    forever begin
      #1;
      if (!bus_wait) break;
      waits++;
      @(negedge clk);
    end
    d = bus_rdata; err = bus_err;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [31:0] d; logic e; int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset values, R5 flush out of reset
    check(cache_en == 1 && bad_write_err == 1 && power_down == 0, "R1 reset outputs",
          {cache_en, bad_write_err, power_down}, 3'b110);
    check(flush_req == 1, "R5 flush_req after reset", flush_req, 1);
    rd(2, d, e, w);
    check(d == 32'h2, "R5 status during reset flush", d, 32'h2);
    rd(0, d, e, w);
    check(d == 32'h3, "R1 ctrl reset read", d, 32'h3);
    @(negedge clk); flush_done = 1; @(negedge clk); flush_done = 0;
    check(flush_req == 0, "R5 flush_req drops after done", flush_req, 0);
    rd(2, d, e, w);
    check(d == 32'h3, "R6 status ready", d, 32'h3);

    // R1 R2 sweep of all control nibbles plus upper bits
    for (int v = 0; v < 32; v++) begin
      logic [31:0] wv; logic [31:0] ex;
      wv = {v[4] ? 28'hFFFFFFF : 28'h0, 4'(v)};
      ex = {28'h0, wv[3], 1'b0, wv[1], wv[0] & ~wv[3]};
      wr(0, wv, e);
      check(cache_en == ex[0] && bad_write_err == ex[1] && power_down == ex[3],
            "R1 R2 ctrl outputs", {power_down, bad_write_err, cache_en}, {ex[3], ex[1], ex[0]});
      rd(0, d, e, w);
      check(d == ex, "R1 R2 ctrl readback", d, ex);
    end
    wr(0, 32'h3, e);

    // R3 flush write 0 does nothing; R3 R4 stall for K cycles
    wr(1, 32'h0, e);
    check(flush_req == 0, "R3 write 0 no flush", flush_req, 0);
    for (int k = 1; k <= 6; k++) begin
      wr(1, 32'h1, e);
      check(flush_req == 1, "R3 flush_req raised", flush_req, 1);
      fork
        begin repeat (k) @(negedge clk); flush_done = 1; @(negedge clk); flush_done = 0; end
        rd(1, d, e, w);
      join
      check(w == k, "R4 wait cycles", w, k);
      check(d == 0, "R3 flush reads 0", d, 0);
      check(flush_req == 0, "R3 flush_req cleared", flush_req, 0);
    end
    rd(1, d, e, w);
    check(w == 0 && d == 0, "R4 idle flush read no wait", w, 0);

    // R6 fifo flags sweep and ignored writes
    for (int f = 0; f < 4; f++) begin
      @(negedge clk); fifo_empty = f[0]; fifo_full = f[1];
      wr(2, 32'hFFFFFFFF, e);
      rd(2, d, e, w);
      check(d == {29'h0, f[1], f[0], 1'b1}, "R6 status flags", d, {29'h0, f[1], f[0], 1'b1});
      check(flush_req == 0 && cache_en == 1, "R6 status write ignored", flush_req, 0);
    end

    // R7 R9 counting and saturation sweep
    for (int n = 0; n <= 20; n++) begin
      int eh, ea;
      wr(3, 32'h0, e); wr(4, 32'h5A, e);
      @(negedge clk); access_pulse = 1; hit_pulse = (n > 0);
      for (int c = 0; c < n + 3; c++) begin
        @(negedge clk);
        if (c + 1 >= n) hit_pulse = 0;
      end
      access_pulse = 0; hit_pulse = 0;
      eh = (n > MAX) ? MAX : n;
      ea = (n + 3 > MAX) ? MAX : n + 3;
      rd(3, d, e, w);
      check(d == 32'(eh), "R7 R9 hit counter", d, eh);
      rd(4, d, e, w);
      check(d == 32'(ea), "R7 R9 access counter", d, ea);
    end

    // R8 write wins over same-cycle pulse
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 3; bus_wdata = 32'h77; hit_pulse = 1; access_pulse = 1;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0; hit_pulse = 0; access_pulse = 0;
    rd(3, d, e, w);
    check(d == 0, "R8 clear beats pulse", d, 0);
    rd(4, d, e, w);
    check(d == MAX, "R8 other counter still counts", d, MAX);

    // R10 unmapped offsets
    for (int a = 5; a < 8; a++) begin
      wr(a, 32'h8, e);
      check(e == 1, "R10 write error", e, 1);
      rd(a, d, e, w);
      check(e == 1 && d == 0, "R10 read error data 0", d, 0);
      check(power_down == 0 && cache_en == 1, "R10 no state change", power_down, 0);
    end
    rd(0, d, e, w);
    check(e == 0 && d == 32'h3, "R10 mapped no error", d, 32'h3);

    finish_up();
  end
endmodule